// File: doc/BRIEF.md
# Little-Endian Byte/Word Access Sequencer

This block connects a load/store request port to a 16-bit memory that has two byte lanes. Each request carries a 16-bit segment, a 16-bit offset, a write flag, a word/byte flag and write data. The block forms a 20-bit physical byte address from the segment and offset. It then runs one or two memory transfers and raises a one-cycle completion pulse. For reads, the result is on the response data port during that pulse.

Data is kept in little-endian order: the least significant byte sits at the physical address and the next byte at the address plus one. A word access at an even address uses both lanes in a single transfer. A word access at an odd address is split into two single-lane transfers on consecutive cycles. The read bytes are merged back into one 16-bit value. The memory samples the address, lane enables, write strobe and write data on the clock edge that ends the cycle in which they are presented. It returns read data on `mem_rdata` during the following cycle, with no stall.

Top module: `le_access_seq`

## Requirements
- R1: The address of the first transfer of every access equals (segment × 16 + offset) modulo 2^20.
- R2: Lane choice follows address bit 0. `mem_lane_en[0]` enables the low lane (`mem_wdata`/`mem_rdata` bits 7:0) and is used at even addresses. `mem_lane_en[1]` enables the high lane (bits 15:8) and is used at odd addresses.
- R3: A word access at an even address is one transfer with `mem_lane_en` = 2'b11 and `mem_wdata` equal to the request data. The completion pulse is visible 3 cycles after the accepting edge, counting the cycle that follows that edge as cycle 1.
- R4: A word access at an odd address is two transfers on consecutive cycles. The first goes to the odd address on the high lane and carries data bits 7:0. The second goes to the address plus one on the low lane and carries data bits 15:8. The completion pulse is visible 4 cycles after the accepting edge.
- R5: A word read returns the byte at the address in bits 7:0 and the byte at the address plus one in bits 15:8, whether the access is aligned or split.
- R6: A byte access is one single-lane transfer. A byte read returns the addressed byte in bits 7:0 with bits 15:8 zero. A byte write uses only request data bits 7:0 and leaves the other byte of that memory word unchanged.
- R7: Word writes that overlap at a shared byte leave the value of the later write in that byte.
- R8: `req_ready` is high only while idle, and a request is taken on an edge where `req_valid` and `req_ready` are both high. `req_ready` stays low until the completion cycle. `rsp_done` is high for exactly one cycle, and `req_ready` is high in that same cycle.
- R9: The second transfer of a split access goes to the first address plus one modulo 2^20, so physical address FFFFFh is followed by 00000h.
- R10: A synchronous active-high reset leaves the block idle in the next cycle: no lane enabled, write strobe low, `req_ready` high, `rsp_done` low. This holds even when reset arrives in the middle of an access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block is idle and will take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit word, 0 = byte |
| req_seg | input | 16 | Segment value |
| req_off | input | 16 | Offset within segment |
| req_wdata | input | 16 | Write data (bits 7:0 only for byte writes) |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read result, valid with `rsp_done` |
| mem_addr | output | 20 | Physical byte address of current transfer |
| mem_lane_en | output | 2 | Lane enables: bit 0 low lane, bit 1 high lane |
| mem_we | output | 1 | Write strobe for current transfer |
| mem_wdata | output | 16 | Write data placed on the enabled lanes |
| mem_rdata | input | 16 | Read data, one cycle after the transfer |

## Verification
The assertions take for granted that the memory accepts every transfer in the cycle it is presented and returns read data in the next cycle. They also assume the request fields matter only on the accepting edge. Under those assumptions, a high-lane transfer followed at once by a low-lane transfer can only be a split access, and the address step between the two can be checked. The bench memory model follows this exact timing with no stall. The stimulus raises `req_valid` only while `req_ready` is high and drops it right after the accepting edge. The reset test is the one case that cuts an access short.

// File: rtl/le_seq_pkg.sv
package le_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FIRST,
    ST_SECOND,
    ST_FINISH
  } seq_state_t;

  // access shape, decided once at acceptance from size and address bit 0
  typedef enum logic [1:0] {
    SH_BYTE_LO,
    SH_BYTE_HI,
    SH_WORD,
    SH_SPLIT
  } acc_shape_t;

endpackage

// File: rtl/le_phys_addr.sv
module le_phys_addr #(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4,
  parameter int PA_W  = SEG_W + SHIFT
) (
  input  logic [SEG_W-1:0] seg,
  input  logic [OFF_W-1:0] off,
  output logic [PA_W-1:0]  pa,
  output logic [PA_W-1:0]  pa_inc
);
  logic [SEG_W+SHIFT-1:0] seg_sh;

  assign seg_sh = {seg, {SHIFT{1'b0}}};
  // both operands at PA_W bits: carry out of the top is dropped (modulo wrap)
  assign pa     = PA_W'(seg_sh) + PA_W'(off);
  assign pa_inc = pa + PA_W'(1);
endmodule

// File: rtl/le_lane_steer.sv
module le_lane_steer
  import le_seq_pkg::*;
#(
  parameter int LANE_W = 8,
  parameter int DATA_W = 2 * LANE_W
) (
  input  acc_shape_t        shape,
  input  logic              second,
  input  logic [DATA_W-1:0] data,
  output logic [1:0]        lanes,
  output logic [DATA_W-1:0] wbus
);
  always_comb begin
    lanes = 2'b00;
    wbus  = '0;
    unique case (shape)
      SH_BYTE_LO: begin
        lanes = 2'b01;
        wbus  = {{LANE_W{1'b0}}, data[LANE_W-1:0]};
      end
      SH_BYTE_HI: begin
        lanes = 2'b10;
        wbus  = {data[LANE_W-1:0], {LANE_W{1'b0}}};
      end
      SH_WORD: begin
        lanes = 2'b11;
        wbus  = data;
      end
      SH_SPLIT: begin
        if (second) begin
          lanes = 2'b01;
          wbus  = {{LANE_W{1'b0}}, data[DATA_W-1:LANE_W]};
        end else begin
          lanes = 2'b10;
          wbus  = {data[LANE_W-1:0], {LANE_W{1'b0}}};
        end
      end
      default: begin
        lanes = 2'b00;
        wbus  = '0;
      end
    endcase
  end
endmodule

// File: rtl/le_read_merge.sv
module le_read_merge
  import le_seq_pkg::*;
#(
  parameter int LANE_W = 8,
  parameter int DATA_W = 2 * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  acc_shape_t        shape,
  input  logic              hold_en,
  input  logic              final_en,
  input  logic [DATA_W-1:0] rbus,
  output logic [DATA_W-1:0] rdata
);
  logic [LANE_W-1:0] lo_hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_hold <= '0;
      rdata   <= '0;
    end else begin
      // first half of a split read arrives on the high lane
      if (hold_en) lo_hold <= rbus[DATA_W-1:LANE_W];
      if (final_en) begin
        unique case (shape)
          SH_BYTE_LO: rdata <= {{LANE_W{1'b0}}, rbus[LANE_W-1:0]};
          SH_BYTE_HI: rdata <= {{LANE_W{1'b0}}, rbus[DATA_W-1:LANE_W]};
          SH_WORD:    rdata <= rbus;
          SH_SPLIT:   rdata <= {rbus[LANE_W-1:0], lo_hold};
          default:    rdata <= rbus;
        endcase
      end
    end
  end
endmodule

// File: rtl/le_access_seq.sv
module le_access_seq
  import le_seq_pkg::*;
#(
  parameter int SEG_W  = 16,
  parameter int OFF_W  = 16,
  parameter int SHIFT  = 4,
  parameter int LANE_W = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic                      req_write,
  input  logic                      req_word,
  input  logic [SEG_W-1:0]          req_seg,
  input  logic [OFF_W-1:0]          req_off,
  input  logic [2*LANE_W-1:0]       req_wdata,
  output logic                      rsp_done,
  output logic [2*LANE_W-1:0]       rsp_rdata,
  output logic [SEG_W+SHIFT-1:0]    mem_addr,
  output logic [1:0]                mem_lane_en,
  output logic                      mem_we,
  output logic [2*LANE_W-1:0]       mem_wdata,
  input  logic [2*LANE_W-1:0]       mem_rdata
);
  localparam int PA_W   = SEG_W + SHIFT;
  localparam int DATA_W = 2 * LANE_W;
  localparam int NPHASE = 2;

  seq_state_t        state;
  acc_shape_t        shape_q;
  acc_shape_t        shape_in;
  logic              write_q;
  logic [DATA_W-1:0] wdata_q;
  logic [PA_W-1:0]   pa_now;
  logic [PA_W-1:0]   pa_inc_now;
  logic [PA_W-1:0]   pa_inc_q;

  acc_shape_t        ph_shape [NPHASE];
  logic [DATA_W-1:0] ph_data  [NPHASE];
  logic [1:0]        ph_lanes [NPHASE];
  logic [DATA_W-1:0] ph_wbus  [NPHASE];

  le_phys_addr #(
    .SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT), .PA_W(PA_W)
  ) u_pa (
    .seg    (req_seg),
    .off    (req_off),
    .pa     (pa_now),
    .pa_inc (pa_inc_now)
  );

  always_comb begin
    if (req_word) shape_in = pa_now[0] ? SH_SPLIT   : SH_WORD;
    else          shape_in = pa_now[0] ? SH_BYTE_HI : SH_BYTE_LO;
  end

  // phase 0 steers the incoming request, phase 1 the stored second half
  assign ph_shape[0] = shape_in;
  assign ph_data[0]  = req_wdata;
  assign ph_shape[1] = shape_q;
  assign ph_data[1]  = wdata_q;

  for (genvar p = 0; p < NPHASE; p++) begin : g_phase
    le_lane_steer #(.LANE_W(LANE_W), .DATA_W(DATA_W)) u_steer (
      .shape  (ph_shape[p]),
      .second (1'(p)),
      .data   (ph_data[p]),
      .lanes  (ph_lanes[p]),
      .wbus   (ph_wbus[p])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      shape_q     <= SH_BYTE_LO;
      write_q     <= 1'b0;
      wdata_q     <= '0;
      pa_inc_q    <= '0;
      mem_addr    <= '0;
      mem_lane_en <= 2'b00;
      mem_we      <= 1'b0;
      mem_wdata   <= '0;
      req_ready   <= 1'b1;
      rsp_done    <= 1'b0;
    end else begin
      rsp_done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_valid && req_ready) begin
            shape_q     <= shape_in;
            write_q     <= req_write;
            wdata_q     <= req_wdata;
            pa_inc_q    <= pa_inc_now;
            mem_addr    <= pa_now;
            mem_lane_en <= ph_lanes[0];
            mem_wdata   <= ph_wbus[0];
            mem_we      <= req_write;
            req_ready   <= 1'b0;
            state       <= ST_FIRST;
          end
        end
        ST_FIRST: begin
          if (shape_q == SH_SPLIT) begin
            mem_addr    <= pa_inc_q;
            mem_lane_en <= ph_lanes[1];
            mem_wdata   <= ph_wbus[1];
            state       <= ST_SECOND;
          end else begin
            mem_lane_en <= 2'b00;
            mem_we      <= 1'b0;
            mem_wdata   <= '0;
            state       <= ST_FINISH;
          end
        end
        ST_SECOND: begin
          mem_lane_en <= 2'b00;
          mem_we      <= 1'b0;
          mem_wdata   <= '0;
          state       <= ST_FINISH;
        end
        ST_FINISH: begin
          rsp_done  <= 1'b1;
          req_ready <= 1'b1;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  le_read_merge #(.LANE_W(LANE_W), .DATA_W(DATA_W)) u_merge (
    .clk      (clk),
    .rst      (rst),
    .shape    (shape_q),
    .hold_en  (state == ST_SECOND && !write_q),
    .final_en (state == ST_FINISH && !write_q),
    .rbus     (mem_rdata),
    .rdata    (rsp_rdata)
  );
endmodule

// File: rtl/le_access_seq_chk.sv
module le_access_seq_chk #(
  parameter int PA_W = 20
) (
  input logic            clk,
  input logic            rst,
  input logic            req_ready,
  input logic            rsp_done,
  input logic [PA_W-1:0] mem_addr,
  input logic [1:0]      mem_lane_en,
  input logic            mem_we
);
  logic [PA_W-1:0] addr_plus1;
  assign addr_plus1 = mem_addr + PA_W'(1);

  // R2
  lane_lo_even_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_lane_en == 2'b01) |-> !mem_addr[0]);

  // R2
  lane_hi_odd_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_lane_en == 2'b10) |-> mem_addr[0]);

  // R3
  word_even_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_lane_en == 2'b11) |-> !mem_addr[0]);

  // R4 R9
  split_step_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_lane_en == 2'b01 && $past(mem_lane_en) == 2'b10) |-> mem_addr == $past(addr_plus1));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);

  // R8
  done_ready_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_done |-> req_ready);

  // R8
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_lane_en != 2'b00) |-> !req_ready);

  // R6
  we_needs_lane_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_lane_en != 2'b00));

  // R10
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (mem_lane_en == 2'b00 && !mem_we && req_ready && !rsp_done));
endmodule

bind le_access_seq le_access_seq_chk #(.PA_W(PA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_ready   (req_ready),
  .rsp_done    (rsp_done),
  .mem_addr    (mem_addr),
  .mem_lane_en (mem_lane_en),
  .mem_we      (mem_we)
);

// File: tb/sim_le_access_seq.sv
module sim_le_access_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic        req_word = 1'b0;
  logic [15:0] req_seg = '0;
  logic [15:0] req_off = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_done;
  logic [15:0] rsp_rdata;
  logic [19:0] mem_addr;
  logic [1:0]  mem_lane_en;
  logic        mem_we;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  always #2 clk = ~clk;

  le_access_seq u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_word(req_word), .req_seg(req_seg),
    .req_off(req_off), .req_wdata(req_wdata), .rsp_done(rsp_done),
    .rsp_rdata(rsp_rdata), .mem_addr(mem_addr), .mem_lane_en(mem_lane_en),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // memory model: 1024 bytes aliased on address bits 9:0, data one cycle later
  logic [7:0] mem [1024];
  initial for (int i = 0; i < 1024; i++) mem[i] = 8'h00;

  always @(posedge clk) begin
    if (mem_lane_en != 2'b00) begin
      mem_rdata <= {mem[{mem_addr[9:1], 1'b1}], mem[{mem_addr[9:1], 1'b0}]};
      if (mem_we && mem_lane_en[0]) mem[{mem_addr[9:1], 1'b0}] <= mem_wdata[7:0];
      if (mem_we && mem_lane_en[1]) mem[{mem_addr[9:1], 1'b1}] <= mem_wdata[15:8];
    end
  end

  // transfer monitor
  int          nx = 0;
  logic [19:0] t_addr [2];
  logic [1:0]  t_lane [2];
  logic [15:0] t_wbus [2];
  always @(posedge clk) begin
    if (!rst && mem_lane_en != 2'b00) begin
      if (nx < 2) begin
        t_addr[nx] <= mem_addr;
        t_lane[nx] <= mem_lane_en;
        t_wbus[nx] <= mem_wdata;
      end
      nx <= nx + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // write, word, seg, off, wdata, expected read, expected transfers
  localparam int NV = 16;
  localparam logic [67:0] VEC [NV] = '{
    {1'b1, 1'b1, 16'h2000, 16'h0100, 16'hABCD, 16'h0000, 2'd1},
    {1'b0, 1'b1, 16'h2000, 16'h0100, 16'h0000, 16'hABCD, 2'd1},
    {1'b0, 1'b0, 16'h2000, 16'h0100, 16'h0000, 16'h00CD, 2'd1},
    {1'b0, 1'b0, 16'h2000, 16'h0101, 16'h0000, 16'h00AB, 2'd1},
    {1'b1, 1'b1, 16'h2000, 16'h0101, 16'h5678, 16'h0000, 2'd2},
    {1'b0, 1'b1, 16'h2000, 16'h0100, 16'h0000, 16'h78CD, 2'd1},
    {1'b0, 1'b1, 16'h2000, 16'h0101, 16'h0000, 16'h5678, 2'd2},
    {1'b1, 1'b0, 16'h2000, 16'h0103, 16'hAA12, 16'h0000, 2'd1},
    {1'b0, 1'b1, 16'h2000, 16'h0102, 16'h0000, 16'h1256, 2'd1},
    {1'b0, 1'b1, 16'h2010, 16'h0001, 16'h0000, 16'h5678, 2'd2},
    {1'b1, 1'b1, 16'hFFFF, 16'h000F, 16'hBEEF, 16'h0000, 2'd2},
    {1'b0, 1'b1, 16'h0000, 16'h0000, 16'h0000, 16'h00BE, 2'd1},
    {1'b0, 1'b1, 16'hF000, 16'hFFFF, 16'h0000, 16'hBEEF, 2'd2},
    {1'b0, 1'b1, 16'hFFFF, 16'h0010, 16'h0000, 16'h00BE, 2'd1},
    {1'b1, 1'b0, 16'h0000, 16'h0001, 16'h9977, 16'h0000, 2'd1},
    {1'b0, 1'b1, 16'h0000, 16'h0000, 16'h0000, 16'h77BE, 2'd1}
  };

  task automatic run_access(input bit wr, input bit wd, input logic [15:0] seg,
                            input logic [15:0] off, input logic [15:0] wdat,
                            input logic [15:0] exp, input int xf);
    logic [20:0] sum;
    logic [19:0] pa_exp;
    logic [19:0] pa2_exp;
    logic [1:0]  lane_exp;
    int          cyc;
    sum     = {5'b0, seg, 4'h0} + {5'b0, off};
    pa_exp  = sum[19:0];
    pa2_exp = pa_exp + 20'd1;
    if (wd) lane_exp = pa_exp[0] ? 2'b10 : 2'b11;
    else    lane_exp = pa_exp[0] ? 2'b10 : 2'b01;
    @(negedge clk);
    nx        = 0;
    req_valid = 1'b1;
    req_write = wr;
    req_word  = wd;
    req_seg   = seg;
    req_off   = off;
    req_wdata = wdat;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1;
    chk(req_ready == 1'b0, "R8 busy ready", 32'(req_ready), 32'h0);
    while (!rsp_done && cyc < 20) begin
      @(negedge clk);
      cyc++;
    end
    // R3 R4 R6: transfer count and completion latency
    chk(nx == xf, "R3/R4 transfer count", 32'(nx), 32'(xf));
    chk(cyc == xf + 2, "R3/R4 latency", 32'(cyc), 32'(xf + 2));
    chk(req_ready == 1'b1, "R8 ready with done", 32'(req_ready), 32'h1);
    // R1, R2 first transfer
    chk(t_addr[0] == pa_exp, "R1 address", 32'(t_addr[0]), 32'(pa_exp));
    chk(t_lane[0] == lane_exp, "R2 lanes", 32'(t_lane[0]), 32'(lane_exp));
    if (xf == 2) begin
      // R4 R9 second transfer
      chk(t_addr[1] == pa2_exp, "R9 second address", 32'(t_addr[1]), 32'(pa2_exp));
      chk(t_lane[1] == 2'b01, "R4 second lane", 32'(t_lane[1]), 32'h1);
    end
    if (wr) begin
      if (wd && xf == 1)
        chk(t_wbus[0] == wdat, "R3 word lanes data", 32'(t_wbus[0]), 32'(wdat));
      else if (wd) begin
        chk(t_wbus[0][15:8] == wdat[7:0], "R4 first byte data", 32'(t_wbus[0][15:8]), 32'(wdat[7:0]));
        chk(t_wbus[1][7:0] == wdat[15:8], "R4 second byte data", 32'(t_wbus[1][7:0]), 32'(wdat[15:8]));
      end else if (pa_exp[0])
        chk(t_wbus[0][15:8] == wdat[7:0], "R6 byte high lane", 32'(t_wbus[0][15:8]), 32'(wdat[7:0]));
      else
        chk(t_wbus[0][7:0] == wdat[7:0], "R6 byte low lane", 32'(t_wbus[0][7:0]), 32'(wdat[7:0]));
    end else begin
      // R5 R6 R7 read result
      chk(rsp_rdata == exp, "R5/R6/R7 read data", 32'(rsp_rdata), 32'(exp));
    end
    @(negedge clk);
    chk(rsp_done == 1'b0, "R8 done one cycle", 32'(rsp_done), 32'h0);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #400000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(mem_lane_en == 2'b00, "R10 lanes idle", 32'(mem_lane_en), 32'h0);
    chk(mem_we == 1'b0, "R10 we low", 32'(mem_we), 32'h0);
    chk(req_ready == 1'b1, "R10 ready", 32'(req_ready), 32'h1);
    chk(rsp_done == 1'b0, "R10 done low", 32'(rsp_done), 32'h0);

    // R8: no request, no transfer
    nx = 0;
    repeat (5) @(negedge clk);
    chk(nx == 0, "R8 idle no transfer", 32'(nx), 32'h0);

    for (int i = 0; i < NV; i++) begin
      run_access(VEC[i][67], VEC[i][66], VEC[i][65:50], VEC[i][49:34],
                 VEC[i][33:18], VEC[i][17:2], int'(VEC[i][1:0]));
    end

    // R10: reset in the middle of a split read
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_word = 1'b1;
    req_seg = 16'h2000; req_off = 16'h0101;
    @(negedge clk);
    req_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    chk(mem_lane_en == 2'b00, "R10 mid-access lanes", 32'(mem_lane_en), 32'h0);
    chk(mem_we == 1'b0, "R10 mid-access we", 32'(mem_we), 32'h0);
    chk(req_ready == 1'b1, "R10 mid-access ready", 32'(req_ready), 32'h1);
    chk(rsp_done == 1'b0, "R10 mid-access done", 32'(rsp_done), 32'h0);
    rst = 1'b0;
    // block usable again after reset
    run_access(1'b0, 1'b1, 16'h2000, 16'h0101, 16'h0000, 16'h5678, 2);

    finish_run();
  end
endmodule